// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the integer register file of a small 32-bit RISC core. Software always addresses sixteen architectural registers through a 4-bit number. The physical register behind each number depends on a 5-bit processor-mode input. Ordinary execution uses a common bank. Each exception mode brings in private copies of some registers, so that a handler can run without first saving the interrupted context.

There are two combinational read ports and one write port, and the mode input selects the bank for all three. Storage holds 31 physical general registers. It also holds one current status word, shared by every mode, and one saved status word for each of the five exception modes. Register 15 is stored like any other register. Program-counter stepping, instruction decode and the rules for updating status flags belong to the core around this block.

Top module: `mode_bank_rf`

## Requirements
- R1: Reset clears all 37 registers to zero: every general index in every mode, the saved status word and the current status word all read 0 after reset.
- R2: Mode codes are 10000 user, 10001 fast interrupt, 10010 interrupt, 10011 supervisor, 10111 abort, 11011 undefined and 11111 system. User and system modes address the same bank. Any other code selects the user bank.
- R3: In fast-interrupt mode, indices 8 to 14 reach seven registers private to that mode. Writes to them are not seen from user mode, and user-mode writes to those indices are not seen from fast-interrupt mode.
- R4: Interrupt, supervisor, abort and undefined modes each have their own private registers at indices 13 and 14. These are separate from each other, from the user bank and from the fast-interrupt bank.
- R5: Indices 0 to 7 and 15 name the same register in every mode. Indices 8 to 12 name the user register in every mode except fast interrupt.
- R6: The two read ports are combinational and independent: each returns the register its own index selects in the current mode, in the same cycle.
- R7: A write takes effect at the rising clock edge. A read of the register being written in that same cycle returns the old value, and the new value from the next cycle on.
- R8: Each of the five exception modes has its own saved status word, written and read through the saved-status port while that mode is selected.
- R9: In user or system mode the saved-status port reads 0, and a write to it changes no saved status word.
- R10: The current status word is a single register shared by all modes, written through its own enable and read on its own output.
- R11: While wr_en is low, no general register changes, whatever wr_idx and wr_data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 5 | Current processor mode code |
| ra_idx | input | 4 | Read port A architectural index |
| ra_data | output | 32 | Read port A data |
| rb_idx | input | 4 | Read port B architectural index |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Write architectural index |
| wr_data | input | 32 | Write data |
| sav_we | input | 1 | Saved status write enable for the current mode |
| sav_wdata | input | 32 | Saved status write data |
| sav_rdata | output | 32 | Saved status of the current mode |
| cur_we | input | 1 | Current status write enable |
| cur_wdata | input | 32 | Current status write data |
| cur_rdata | output | 32 | Current status word |

## Verification
A write and a read of the same physical register can fall in one cycle. To provoke this, the bench raises wr_en with a new value while read port A points at the same index and port B points at a neighbour. It then samples both ports before the edge, expecting the old value on A and an unrelated value on B, and samples A again after the edge, expecting the new value. The bench also combines a mode change with a write through an index that is banked in one mode and shared in another. It judges each case by reading every affected bank afterwards through the ordinary ports.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

  localparam int NARCH     = 16;
  localparam int IDX_W     = $clog2(NARCH);
  localparam int MODE_W    = 5;

  localparam int FIQ_FIRST = 8;
  localparam int FIQ_CNT   = 7;
  localparam int EXC_FIRST = 13;
  localparam int EXC_CNT   = 2;
  localparam int N_SMALL   = 4;

  localparam int FIQ_BASE  = NARCH;
  localparam int EXC_BASE  = NARCH + FIQ_CNT;
  localparam int NPHYS     = NARCH + FIQ_CNT + EXC_CNT * N_SMALL;
  localparam int PHYS_W    = $clog2(NPHYS);

  localparam int NSAV      = 1 + N_SMALL;
  localparam int SAV_W     = $clog2(NSAV);

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

endpackage

// File: rtl/mbrf_mode_dec.sv
module mbrf_mode_dec
  import mbrf_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output bank_e             bank
);

  always_comb begin
    case (mode)
      MODE_FIQ: bank = BK_FIQ;
      MODE_IRQ: bank = BK_IRQ;
      MODE_SVC: bank = BK_SVC;
      MODE_ABT: bank = BK_ABT;
      MODE_UND: bank = BK_UND;
      default:  bank = BK_USR;  // user, system and unknown codes
    endcase
  end

endmodule

// File: rtl/mbrf_map.sv
module mbrf_map
  import mbrf_pkg::*;
(
  input  bank_e             bank,
  input  logic [IDX_W-1:0]  arch,
  output logic [PHYS_W-1:0] phys
);

  int a_i;
  int slot_i;
  logic in_fiq_win;
  logic in_exc_win;
  logic small_bank;

  always_comb begin
    a_i        = int'(arch);
    slot_i     = int'(bank) - int'(BK_IRQ);
    in_fiq_win = (a_i >= FIQ_FIRST) && (a_i < FIQ_FIRST + FIQ_CNT);
    in_exc_win = (a_i >= EXC_FIRST) && (a_i < EXC_FIRST + EXC_CNT);
    small_bank = (bank == BK_IRQ) || (bank == BK_SVC) ||
                 (bank == BK_ABT) || (bank == BK_UND);
  end

  always_comb begin
    phys = PHYS_W'(a_i);
    if ((bank == BK_FIQ) && in_fiq_win)
      phys = PHYS_W'(FIQ_BASE + a_i - FIQ_FIRST);
    else if (small_bank && in_exc_win)
      phys = PHYS_W'(EXC_BASE + slot_i * EXC_CNT + a_i - EXC_FIRST);
  end

endmodule

// File: rtl/mbrf_gpr_store.sv
module mbrf_gpr_store
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHYS_W-1:0] rd_a_phys,
  input  logic [PHYS_W-1:0] rd_b_phys,
  input  logic              we,
  input  logic [PHYS_W-1:0] wr_phys,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);

  logic [DATA_W-1:0] rf_q [NPHYS];

  for (genvar g = 0; g < NPHYS; g++) begin : g_cell
    logic              ld;
    logic [DATA_W-1:0] d;
    logic [DATA_W-1:0] q;

    always_comb begin
      ld = we && (wr_phys == PHYS_W'(g));
      d  = ld ? wdata : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
    end

    assign rf_q[g] = q;
  end

  assign rd_a = rf_q[rd_a_phys];
  assign rd_b = rf_q[rd_b_phys];

endmodule

// File: rtl/mbrf_psr_store.sv
module mbrf_psr_store
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             bank,
  input  logic              sav_we,
  input  logic [DATA_W-1:0] sav_wdata,
  output logic [DATA_W-1:0] sav_rdata,
  input  logic              cur_we,
  input  logic [DATA_W-1:0] cur_wdata,
  output logic [DATA_W-1:0] cur_rdata
);

  logic              has_sav;
  logic [SAV_W-1:0]  sav_sel;
  logic [DATA_W-1:0] sav_q [NSAV];
  logic [DATA_W-1:0] cur_d;
  logic [DATA_W-1:0] cur_q;

  always_comb begin
    has_sav = (bank != BK_USR);
    sav_sel = has_sav ? SAV_W'(int'(bank) - 1) : '0;
  end

  for (genvar s = 0; s < NSAV; s++) begin : g_sav
    logic              ld;
    logic [DATA_W-1:0] d;
    logic [DATA_W-1:0] q;

    always_comb begin
      ld = sav_we && has_sav && (sav_sel == SAV_W'(s));
      d  = ld ? sav_wdata : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
    end

    assign sav_q[s] = q;
  end

  always_comb begin
    cur_d     = cur_we ? cur_wdata : cur_q;
    sav_rdata = has_sav ? sav_q[sav_sel] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cur_we) cur_q <= cur_d;
  end

  assign cur_rdata = cur_q;

endmodule

// File: rtl/mode_bank_rf.sv
module mode_bank_rf
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sav_we,
  input  logic [DATA_W-1:0] sav_wdata,
  output logic [DATA_W-1:0] sav_rdata,
  input  logic              cur_we,
  input  logic [DATA_W-1:0] cur_wdata,
  output logic [DATA_W-1:0] cur_rdata
);

  localparam int NPORT = 3;  // read A, read B, write

  logic rst_q1;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_sync_n <= rst_q1;
    end
  end

  bank_e bank;

  mbrf_mode_dec u_dec (
    .mode (mode),
    .bank (bank)
  );

  logic [IDX_W-1:0]  arch_idx [NPORT];
  logic [PHYS_W-1:0] phys_idx [NPORT];

  assign arch_idx[0] = ra_idx;
  assign arch_idx[1] = rb_idx;
  assign arch_idx[2] = wr_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    mbrf_map u_map (
      .bank (bank),
      .arch (arch_idx[p]),
      .phys (phys_idx[p])
    );
  end

  mbrf_gpr_store #(.DATA_W(DATA_W)) u_gpr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_a_phys (phys_idx[0]),
    .rd_b_phys (phys_idx[1]),
    .we        (wr_en),
    .wr_phys   (phys_idx[2]),
    .wdata     (wr_data),
    .rd_a      (ra_data),
    .rd_b      (rb_data)
  );

  mbrf_psr_store #(.DATA_W(DATA_W)) u_psr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bank      (bank),
    .sav_we    (sav_we),
    .sav_wdata (sav_wdata),
    .sav_rdata (sav_rdata),
    .cur_we    (cur_we),
    .cur_wdata (cur_wdata),
    .cur_rdata (cur_rdata)
  );

endmodule

// File: rtl/mbrf_chk.sv
module mbrf_chk
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_ok,
  input logic [MODE_W-1:0] mode,
  input logic [IDX_W-1:0]  ra_idx,
  input logic [DATA_W-1:0] ra_data,
  input logic [IDX_W-1:0]  rb_idx,
  input logic [DATA_W-1:0] rb_data,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              sav_we,
  input logic [DATA_W-1:0] sav_rdata,
  input logic              cur_we,
  input logic [DATA_W-1:0] cur_wdata,
  input logic [DATA_W-1:0] cur_rdata
);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(rst_ok) |-> (ra_data == '0 && rb_data == '0 && sav_rdata == '0 && cur_rdata == '0)); // R1

  AST_USR_NO_SAVED: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode == MODE_USR || mode == MODE_SYS) |-> sav_rdata == '0); // R9

  AST_WRITE_LANDS_A: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && $past(wr_en) && $stable(mode) && ra_idx == $past(wr_idx))
      |-> ra_data == $past(wr_data)); // R7

  AST_WRITE_LANDS_B: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && $past(wr_en) && $stable(mode) && rb_idx == $past(wr_idx))
      |-> rb_data == $past(wr_data)); // R6

  AST_LOW_SHARED: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && $past(wr_en) && $past(wr_idx) < 4'd8 && ra_idx == $past(wr_idx))
      |-> ra_data == $past(wr_data)); // R5

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && !$past(wr_en) && $stable(mode) && $stable(ra_idx))
      |-> $stable(ra_data)); // R11

  AST_SAVED_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && !$past(sav_we) && $stable(mode)) |-> $stable(sav_rdata)); // R8

  AST_CUR_WRITE: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && $past(cur_we)) |-> cur_rdata == $past(cur_wdata)); // R10

endmodule

bind mode_bank_rf mbrf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .mode      (mode),
  .ra_idx    (ra_idx),
  .ra_data   (ra_data),
  .rb_idx    (rb_idx),
  .rb_data   (rb_data),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .sav_we    (sav_we),
  .sav_rdata (sav_rdata),
  .cur_we    (cur_we),
  .cur_wdata (cur_wdata),
  .cur_rdata (cur_rdata)
);

// File: tb/test_mode_bank_rf.sv
`timescale 1ns/1ps
module test_mode_bank_rf;

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  mode;
  logic [3:0]  ra_idx, rb_idx, wr_idx;
  logic [31:0] ra_data, rb_data, wr_data;
  logic        wr_en, sav_we, cur_we;
  logic [31:0] sav_wdata, sav_rdata, cur_wdata, cur_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  mode_bank_rf i_mode_bank_rf (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sav_we(sav_we), .sav_wdata(sav_wdata), .sav_rdata(sav_rdata),
    .cur_we(cur_we), .cur_wdata(cur_wdata), .cur_rdata(cur_rdata)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_wr(input logic [4:0] m, input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    mode = m; wr_idx = idx; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] m, input logic [3:0] idx, output logic [31:0] v);
    mode = m; ra_idx = idx;
    #1 v = ra_data;
  endtask

  task automatic do_sav(input logic [4:0] m, input logic [31:0] d);
    @(negedge clk);
    mode = m; sav_wdata = d; sav_we = 1'b1;
    @(negedge clk);
    sav_we = 1'b0;
  endtask

  task automatic rd_sav(input logic [4:0] m, output logic [31:0] v);
    mode = m;
    #1 v = sav_rdata;
  endtask

  // R1
  task automatic t_reset();
    logic [31:0] v;
    logic [4:0] ml [7] = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS};
    for (int k = 0; k < 7; k++) begin
      for (int i = 0; i < 16; i++) begin
        rd(ml[k], 4'(i), v);
        check("R1 gpr after reset", v, 32'h0);
      end
      rd_sav(ml[k], v);
      check("R1 saved after reset", v, 32'h0);
    end
    check("R1 cur after reset", cur_rdata, 32'h0);
  endtask

  // R5: shared indices
  task automatic t_shared();
    logic [31:0] v;
    logic [4:0] ml [5] = '{M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND};
    for (int i = 0; i < 16; i++) do_wr(M_USR, 4'(i), 32'h1000 + i);
    for (int k = 0; k < 5; k++)
      for (int i = 0; i < 16; i++)
        if (i < 8 || i == 15) begin
          rd(ml[k], 4'(i), v);
          check("R5 low/15 shared", v, 32'h1000 + i);
        end
    for (int i = 8; i < 13; i++) begin
      rd(M_SVC, 4'(i), v);
      check("R5 8-12 shared outside fiq", v, 32'h1000 + i);
    end
  endtask

  // R3
  task automatic t_fiq_bank();
    logic [31:0] v;
    for (int i = 8; i < 15; i++) begin
      rd(M_FIQ, 4'(i), v);
      check("R3 fiq private untouched by user", v, 32'h0);
    end
    for (int i = 8; i < 15; i++) do_wr(M_FIQ, 4'(i), 32'h2000 + i);
    for (int i = 8; i < 15; i++) begin
      rd(M_FIQ, 4'(i), v);
      check("R3 fiq readback", v, 32'h2000 + i);
      rd(M_USR, 4'(i), v);
      check("R3 user unchanged", v, 32'h1000 + i);
    end
  endtask

  // R2: system shares user bank
  task automatic t_system();
    logic [31:0] v;
    do_wr(M_SYS, 4'd13, 32'h5555_0013);
    rd(M_USR, 4'd13, v);
    check("R2 sys write seen in user", v, 32'h5555_0013);
    do_wr(M_USR, 4'd9, 32'h5555_0009);
    rd(M_SYS, 4'd9, v);
    check("R2 user write seen in sys", v, 32'h5555_0009);
  endtask

  // R4
  task automatic t_exc_banks();
    logic [31:0] v;
    logic [4:0] ml [4] = '{M_IRQ, M_SVC, M_ABT, M_UND};
    for (int k = 0; k < 4; k++) begin
      do_wr(ml[k], 4'd13, 32'h3000 + 32'(k) * 32'h100 + 13);
      do_wr(ml[k], 4'd14, 32'h3000 + 32'(k) * 32'h100 + 14);
    end
    for (int k = 0; k < 4; k++) begin
      rd(ml[k], 4'd13, v);
      check("R4 banked r13", v, 32'h3000 + 32'(k) * 32'h100 + 13);
      rd(ml[k], 4'd14, v);
      check("R4 banked r14", v, 32'h3000 + 32'(k) * 32'h100 + 14);
      rd(ml[k], 4'd12, v);
      check("R4 r12 still user", v, 32'h100C);
    end
    rd(M_USR, 4'd13, v); check("R4 user r13 kept", v, 32'h5555_0013);
    rd(M_USR, 4'd14, v); check("R4 user r14 kept", v, 32'h100E);
    rd(M_FIQ, 4'd13, v); check("R4 fiq r13 kept", v, 32'h200D);
  endtask

  // R2: unknown codes fall back to user bank
  task automatic t_illegal();
    logic [31:0] v;
    do_wr(5'b00000, 4'd14, 32'h7777_000E);
    rd(M_USR, 4'd14, v);
    check("R2 illegal mode uses user bank", v, 32'h7777_000E);
    rd(5'b10100, 4'd14, v);
    check("R2 other illegal code reads user", v, 32'h7777_000E);
    rd(M_IRQ, 4'd14, v);
    check("R2 irq r14 untouched", v, 32'h300E);
  endtask

  // R7 and R6: write and read of one register in the same cycle
  task automatic t_same_cycle();
    @(negedge clk);
    mode = M_USR; wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'hCAFE_0003;
    ra_idx = 4'd3; rb_idx = 4'd4;
    #1;
    check("R7 old value before edge", ra_data, 32'h1003);
    check("R6 port B independent", rb_data, 32'h1004);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R7 new value after edge", ra_data, 32'hCAFE_0003);
    rb_idx = 4'd3;
    #1;
    check("R6 port B same register", rb_data, 32'hCAFE_0003);
  endtask

  // R11
  task automatic t_wr_disabled();
    logic [31:0] v;
    @(negedge clk);
    mode = M_USR; wr_en = 1'b0; wr_idx = 4'd5; wr_data = 32'hBAD0_0005;
    @(negedge clk);
    @(negedge clk);
    rd(M_USR, 4'd5, v);
    check("R11 no write without enable", v, 32'h1005);
  endtask

  // R8 and R9
  task automatic t_saved();
    logic [31:0] v;
    logic [4:0] ml [5] = '{M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND};
    for (int k = 0; k < 5; k++) do_sav(ml[k], 32'h6000 + k);
    for (int k = 0; k < 5; k++) begin
      rd_sav(ml[k], v);
      check("R8 saved per mode", v, 32'h6000 + k);
    end
    do_sav(M_USR, 32'hDEAD_0001);
    rd_sav(M_USR, v);
    check("R9 user saved reads zero", v, 32'h0);
    do_sav(M_SYS, 32'hDEAD_0002);
    rd_sav(M_SYS, v);
    check("R9 system saved reads zero", v, 32'h0);
    for (int k = 0; k < 5; k++) begin
      rd_sav(ml[k], v);
      check("R9 user write ignored", v, 32'h6000 + k);
    end
  endtask

  // R10
  task automatic t_cur();
    @(negedge clk);
    mode = M_FIQ; cur_wdata = 32'h0000_F00D; cur_we = 1'b1;
    @(negedge clk);
    cur_we = 1'b0; mode = M_USR;
    #1 check("R10 cur shared across modes", cur_rdata, 32'h0000_F00D);
    mode = M_UND;
    #1 check("R10 cur same in undefined", cur_rdata, 32'h0000_F00D);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = M_USR; ra_idx = '0; rb_idx = '0; wr_idx = '0;
    wr_data = '0; wr_en = 1'b0; sav_we = 1'b0; sav_wdata = '0;
    cur_we = 1'b0; cur_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_shared();
    t_fiq_bank();
    t_system();
    t_exc_banks();
    t_illegal();
    t_same_cycle();
    t_wr_disabled();
    t_saved();
    t_cur();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule